// File: doc/BRIEF.md
# Level-Tagged Overflow Capture Timer

This block is an up-counting timer whose advance rate comes from a free-running prescaler with four selectable tap ratios. Each time the counter wraps from all-ones to zero, the block records the level of an external capture pin at that moment. There are two overflow flags, one for a high pin and one for a low pin. In interval mode the pin is not consulted and every wrap sets the low flag. The pin can also clear the counter on a chosen edge polarity, and it raises a one-cycle capture interrupt on a selected edge.

Software reaches the block through a small register bus. Address 0 holds an 8-bit control/status byte and address 1 returns the counter. The two flags use a read-then-write-zero clearing protocol: a flag can be cleared only after a read has shown it as 1. Software can never set a flag. The overflow interrupt is a level that stays high while overflow requests are enabled and either flag is set.

Top module: `ovf_level_timer`

## Requirements
- R1: After reset the control/status byte reads 0x00, the counter reads 0, and both interrupt outputs are low.
- R2: Address 0 is the control/status byte: bit 7 high-level flag, bit 6 low-level flag, bit 5 overflow interrupt enable, bit 4 capture edge select, bits 3:2 clear mode, bits 1:0 clock select. Address 1 returns the counter zero-extended, and writes to it have no effect. When the read strobe is low, the read data is 0x00. Bits 5:0 take a written value at the clock edge that samples the write.
- R3: Clock-select codes 0, 1, 2 and 3 give divide ratios of 2 to the power LOG_DIV0, LOG_DIV1, LOG_DIV2 and LOG_DIV3 (64, 128, 256 and 2048 by default). Counting rising edges from reset release, starting at 1, the counter advances by one on every edge whose index is a multiple of the selected ratio.
- R4: An overflow is an advance that takes the counter from all-ones to 0. With clear mode 00 (interval mode), every overflow sets the low-level flag whatever the pin level.
- R5: With clear mode 01, 10 or 11, an overflow sets the high-level flag if the synchronized pin is high and the low-level flag if it is low. The pin passes through two flip-flops, so the level used at an edge is the pin value sampled two edges earlier.
- R6: Writing 1 to bit 7 or bit 6 has no effect. Writing 0 clears a flag only if a read of address 0 has returned that flag as 1 since it was last cleared. Without such a read the flag stays set.
- R7: When a hardware set and a valid clearing write hit the same flag on the same edge, the flag stays set and the earlier read no longer counts, so a new read is needed before the flag can be cleared.
- R8: ovf_irq is high exactly while bit 5 is 1 and bit 7 or bit 6 is 1.
- R9: Clear mode 01 clears the counter on a pin falling edge, 10 on a rising edge, and 11 on both. The clear lands on the third rising edge after the pin changes, takes priority over an advance, and is never counted as an overflow.
- R10: cap_irq pulses for one cycle on a pin falling edge when bit 4 is 0, or on a rising edge when bit 4 is 1. The pulse is high between the second and third rising edges after the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address (0 control/status, 1 counter) |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe; also arms flag clearing |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data, 0 when bus_rd is low |
| cap_in | input | 1 | Asynchronous capture pin |
| ovf_irq | output | 1 | Overflow interrupt level |
| cap_irq | output | 1 | One-cycle capture edge interrupt |

## Verification
Read data is combinational, so it is compared one time step after the strobes are driven on a falling edge, before the edge that lets the read arm a flag. A write to bits 5:0 affects behaviour from the edge that samples it. A pin change appears as a capture pulse after the second rising edge and as a counter clear at the third. Overflow flags and ovf_irq change at the same edge as the wrap. The bench keeps an edge-indexed arithmetic model that follows these latencies, compares the outputs three time units after every rising edge, and uses literal expected values at the known cycles for the reset, the prescaler phase, the clear/capture delays and the same-edge set-versus-clear case.

// File: rtl/olt_pkg.sv
package olt_pkg;

   localparam int unsigned CTRL_W   = 8;
   localparam int unsigned FLAG_LSB = 6;

   typedef enum logic [1:0] {
      CLR_NONE = 2'b00,
      CLR_FALL = 2'b01,
      CLR_RISE = 2'b10,
      CLR_BOTH = 2'b11
   } clr_mode_e;

   typedef struct packed {
      logic       ovf_hi;
      logic       ovf_lo;
      logic       ovf_ien;
      logic       cap_rise_sel;
      clr_mode_e  clr_mode;
      logic [1:0] clk_sel;
   } ctrl_t;

endpackage

// File: rtl/olt_prescaler.sv
module olt_prescaler #(
   parameter int unsigned LOG_DIV0 = 6,
   parameter int unsigned LOG_DIV1 = 7,
   parameter int unsigned LOG_DIV2 = 8,
   parameter int unsigned LOG_DIV3 = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] clk_sel,
   output logic       tick
);

   localparam int unsigned PRE_W    = LOG_DIV3;
   localparam int unsigned LOGS [4] = '{LOG_DIV0, LOG_DIV1, LOG_DIV2, LOG_DIV3};

   generate
      if (LOG_DIV0 < 1 || LOG_DIV1 < LOG_DIV0 || LOG_DIV2 < LOG_DIV1 || LOG_DIV3 < LOG_DIV2) begin : g_bad_div
         $error("olt_prescaler: divide exponents must be at least 1 and non-decreasing");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [3:0]       tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   generate
      for (genvar g = 0; g < 4; g++) begin : g_tap
         localparam logic [PRE_W-1:0] MASK = {PRE_W{1'b1}} >> (PRE_W - LOGS[g]);
         assign tap[g] = ((pre_q & MASK) == MASK);
      end
   endgenerate

   assign tick = tap[clk_sel];

endmodule

// File: rtl/olt_cap_sync.sv
module olt_cap_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_in,
   output logic level,
   output logic rise,
   output logic fall
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("olt_cap_sync: at least two synchronizer stages are required");
      end
   endgenerate

   logic [SYNC_STAGES:0] sh_q;
   logic                 prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-1:0], cap_in};
   end

   assign level = sh_q[SYNC_STAGES-1];
   assign prev  = sh_q[SYNC_STAGES];
   assign rise  = level & ~prev;
   assign fall  = ~level & prev;

endmodule

// File: rtl/olt_counter.sv
module olt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
   end

   assign wrap = tick & (&cnt_q) & ~clr;
   assign cnt  = cnt_q;

endmodule

// File: rtl/olt_ctrl_reg.sv
module olt_ctrl_reg
   import olt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [7:0]  wdata,
   input  logic        wrap,
   input  logic        level,
   output ctrl_t       ctrl
);

   logic [5:0] cfg_q;
   logic [1:0] flag;
   logic [1:0] hw_set;
   clr_mode_e  mode;

   assign mode      = clr_mode_e'(cfg_q[3:2]);
   assign hw_set[1] = wrap & level & (mode != CLR_NONE);
   assign hw_set[0] = wrap & (~level | (mode == CLR_NONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q <= '0;
      else if (wr_en) cfg_q <= wdata[5:0];
   end

   generate
      for (genvar g = 0; g < 2; g++) begin : g_flag
         logic flag_q;
         logic arm_q;
         logic zap;

         assign zap = wr_en & ~wdata[FLAG_LSB+g] & arm_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
               arm_q  <= 1'b0;
            end else begin
               flag_q <= hw_set[g] | (flag_q & ~zap);
               if (zap)                  arm_q <= 1'b0;
               else if (rd_en && flag_q) arm_q <= 1'b1;
            end
         end

         assign flag[g] = flag_q;
      end
   endgenerate

   assign ctrl = '{ovf_hi:       flag[1],
                   ovf_lo:       flag[0],
                   ovf_ien:      cfg_q[5],
                   cap_rise_sel: cfg_q[4],
                   clr_mode:     mode,
                   clk_sel:      cfg_q[1:0]};

endmodule

// File: rtl/ovf_level_timer.sv
module ovf_level_timer
   import olt_pkg::*;
#(
   parameter int unsigned ADDR_W      = 1,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned LOG_DIV0    = 6,
   parameter int unsigned LOG_DIV1    = 7,
   parameter int unsigned LOG_DIV2    = 8,
   parameter int unsigned LOG_DIV3    = 11,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              cap_in,
   output logic              ovf_irq,
   output logic              cap_irq
);

   generate
      if (ADDR_W < 1 || CNT_W < 2 || CNT_W > CTRL_W) begin : g_bad_cfg
         $error("ovf_level_timer: ADDR_W must be at least 1 and CNT_W between 2 and 8");
      end
   endgenerate

   logic             sel_ctrl, sel_cnt;
   logic             wr_ctrl, rd_ctrl;
   logic             tick, wrap, ctr_clr;
   logic             level, rise, fall;
   logic [CNT_W-1:0] cnt;
   ctrl_t            ctrl;

   assign sel_ctrl = (bus_addr == ADDR_W'(0));
   assign sel_cnt  = (bus_addr == ADDR_W'(1));
   assign wr_ctrl  = bus_wr & sel_ctrl;
   assign rd_ctrl  = bus_rd & sel_ctrl;

   olt_prescaler #(
      .LOG_DIV0 (LOG_DIV0),
      .LOG_DIV1 (LOG_DIV1),
      .LOG_DIV2 (LOG_DIV2),
      .LOG_DIV3 (LOG_DIV3)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_sel (ctrl.clk_sel),
      .tick    (tick)
   );

   olt_cap_sync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_in (cap_in),
      .level  (level),
      .rise   (rise),
      .fall   (fall)
   );

   always_comb begin
      unique case (ctrl.clr_mode)
         CLR_FALL: ctr_clr = fall;
         CLR_RISE: ctr_clr = rise;
         CLR_BOTH: ctr_clr = rise | fall;
         default:  ctr_clr = 1'b0;
      endcase
   end

   olt_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .clr   (ctr_clr),
      .cnt   (cnt),
      .wrap  (wrap)
   );

   olt_ctrl_reg u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_ctrl),
      .rd_en (rd_ctrl),
      .wdata (bus_wdata),
      .wrap  (wrap),
      .level (level),
      .ctrl  (ctrl)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_ctrl)     bus_rdata = ctrl;
         else if (sel_cnt) bus_rdata = CTRL_W'(cnt);
      end
   end

   assign ovf_irq = ctrl.ovf_ien & (ctrl.ovf_hi | ctrl.ovf_lo);
   assign cap_irq = ctrl.cap_rise_sel ? rise : fall;

endmodule

// File: rtl/olt_checker.sv
module olt_checker #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_rd,
   input logic [7:0]       bus_rdata,
   input logic             wr_ctrl,
   input logic [7:0]       bus_wdata,
   input logic [7:0]       ctrl,
   input logic [CNT_W-1:0] cnt,
   input logic             wrap,
   input logic             ovf_irq,
   input logic             cap_irq
);

   // R2: idle read data is zero
   assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == 8'h00));

   // R3: the counter only steps by one or returns to zero
   assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)));

   // R4: a wrap leaves the counter at zero
   assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));

   // R6: flags rise only from a wrap
   assert_hi_hw_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl[7]) |-> $past(wrap));
   assert_lo_hw_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl[6]) |-> $past(wrap));

   // R6: flags fall only after a zero written to their bit
   assert_hi_clear_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl[7]) |-> $past(wr_ctrl && !bus_wdata[7]));
   assert_lo_clear_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl[6]) |-> $past(wr_ctrl && !bus_wdata[6]));

   // R8: no overflow request while disabled
   assert_ovf_irq_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> ctrl[5]);

   // R10: capture request is a single-cycle pulse
   assert_cap_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cap_irq |=> (!cap_irq || (ctrl[4] != $past(ctrl[4]))));

endmodule

bind ovf_level_timer olt_checker #(.CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .wr_ctrl   (wr_ctrl),
   .bus_wdata (bus_wdata),
   .ctrl      (ctrl),
   .cnt       (cnt),
   .wrap      (wrap),
   .ovf_irq   (ovf_irq),
   .cap_irq   (cap_irq)
);

// File: tb/ovf_level_timer_tb_top.sv
`timescale 1ns/1ps
module ovf_level_timer_tb_top;

   localparam int CNT_W    = 4;
   localparam int CNT_MAX  = (1 << CNT_W) - 1;
   localparam int LOGS [4] = '{1, 2, 3, 4};
   localparam int PRE_MOD  = 1 << LOGS[3];

   logic       clk = 1'b0;
   logic       rst_n;
   logic [0:0] bus_addr;
   logic       bus_wr, bus_rd;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata;
   logic       cap_in;
   logic       ovf_irq, cap_irq;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   ovf_level_timer #(
      .ADDR_W   (1),
      .CNT_W    (CNT_W),
      .LOG_DIV0 (LOGS[0]),
      .LOG_DIV1 (LOGS[1]),
      .LOG_DIV2 (LOGS[2]),
      .LOG_DIV3 (LOGS[3])
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cap_in    (cap_in),
      .ovf_irq   (ovf_irq),
      .cap_irq   (cap_irq)
   );

   // Edge-indexed model built from the requirements
   int         m_pre;
   logic [3:0] m_cnt;
   logic [7:0] m_ctrl;
   logic [1:0] m_arm;
   logic       h0, h1, h2;

   always @(posedge clk or negedge rst_n) begin : model
      int   dv;
      logic tk, rs, fl, cl, wr0, rd0, hw_hi, hw_lo, z_hi, z_lo;
      logic [1:0] md;
      if (!rst_n) begin
         m_pre <= 0; m_cnt <= '0; m_ctrl <= '0; m_arm <= '0;
         h0 <= 1'b0; h1 <= 1'b0; h2 <= 1'b0;
      end else begin
         dv    = 1 << LOGS[m_ctrl[1:0]];
         tk    = (((m_pre + 1) % dv) == 0);
         rs    = h1 & ~h2;
         fl    = ~h1 & h2;
         md    = m_ctrl[3:2];
         cl    = (md == 2'd1 && fl) || (md == 2'd2 && rs) || (md == 2'd3 && (rs || fl));
         wr0   = bus_wr && bus_addr == 1'b0;
         rd0   = bus_rd && bus_addr == 1'b0;
         hw_hi = tk && m_cnt == 4'(CNT_MAX) && !cl && h1 && md != 2'd0;
         hw_lo = tk && m_cnt == 4'(CNT_MAX) && !cl && (!h1 || md == 2'd0);
         z_hi  = wr0 && !bus_wdata[7] && m_arm[1];
         z_lo  = wr0 && !bus_wdata[6] && m_arm[0];
         m_pre <= (m_pre + 1) % PRE_MOD;
         m_cnt <= cl ? 4'd0 : (tk ? 4'(m_cnt + 1) : m_cnt);
         m_ctrl[7] <= hw_hi | (m_ctrl[7] & ~z_hi);
         m_ctrl[6] <= hw_lo | (m_ctrl[6] & ~z_lo);
         if (wr0) m_ctrl[5:0] <= bus_wdata[5:0];
         m_arm[1] <= z_hi ? 1'b0 : ((rd0 && m_ctrl[7]) ? 1'b1 : m_arm[1]);
         m_arm[0] <= z_lo ? 1'b0 : ((rd0 && m_ctrl[6]) ? 1'b1 : m_arm[0]);
         h0 <= cap_in; h1 <= h0; h2 <= h1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic bus_write(input logic a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic read_model(input logic a, input string req);
      logic [7:0] e;
      bus_addr = a; bus_rd = 1'b1;
      #1;
      e = a ? 8'(m_cnt) : m_ctrl;
      chk(req, bus_rdata, e);
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // Continuous comparison three time units after every rising edge
   always @(posedge clk) begin
      #3;
      if (rst_n && !done) begin
         chk("R8 ovf_irq", ovf_irq, m_ctrl[5] & (m_ctrl[7] | m_ctrl[6]));
         chk("R10 cap_irq", cap_irq, m_ctrl[4] ? (h1 & ~h2) : (~h1 & h2));
         if (!bus_rd) chk("R2 idle rdata", bus_rdata, 0);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      rst_n = 1'b0; cap_in = 1'b0; bus_addr = '0;
      bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
      repeat (3) @(negedge clk);

      // R1 reset state
      bus_read(1'b0, d); chk("R1 ctrl reset", d, 8'h00);
      bus_read(1'b1, d); chk("R1 counter reset", d, 0);
      chk("R1 ovf_irq reset", ovf_irq, 0);
      chk("R1 cap_irq reset", cap_irq, 0);

      // R3 prescaler phase from reset release, divide 2
      rst_n = 1'b1;
      repeat (10) @(posedge clk);
      @(negedge clk);
      bus_read(1'b1, d); chk("R3 count after 10 edges", d, 5);

      // R2 counter address ignores writes
      bus_write(1'b1, 8'hFF);
      read_model(1'b1, "R2 counter write ignored");

      // Sweep clock selects and clear modes with a toggling pin
      for (int cks = 0; cks < 4; cks++) begin
         for (int md = 0; md < 4; md++) begin
            bus_write(1'b0, 8'(32 | ((md & 1) << 4) | (md << 2) | cks));
            for (int j = 0; j < (8 << cks); j++) begin
               repeat (3 + md + j % 5) @(negedge clk);
               if (j % 4 == 3) cap_in = ~cap_in;
               read_model(1'b0, "R5 flags in sweep");
               read_model(1'b1, "R3 count in sweep");
               if (j % 3 == 2) bus_write(1'b0, {2'b00, m_ctrl[5:0]});
            end
         end
      end

      // R4 and R5 flag choice by mode and steady pin level
      for (int md = 0; md < 4; md++) begin
         for (int lv = 0; lv < 2; lv++) begin
            bus_write(1'b0, 8'(32 | (md << 2)));
            cap_in = lv[0];
            repeat (5) @(negedge clk);
            read_model(1'b0, "R6 arming read");
            bus_write(1'b0, 8'(32 | (md << 2)));
            repeat (80) @(negedge clk);
            bus_read(1'b0, d);
            if (md == 0) chk("R4 interval sets low flag", d[7:6], 2'b01);
            else         chk("R5 level selects flag", d[7:6], lv ? 2'b10 : 2'b01);
            read_model(1'b0, "R5 model after wraps");
            bus_write(1'b0, 8'(32 | (md << 2)));
         end
      end

      // R7 set wins over a clearing write on the same edge
      cap_in = 1'b1;
      bus_write(1'b0, 8'h24);
      while (!m_ctrl[7]) @(negedge clk);
      bus_read(1'b0, d); chk("R6 flag seen before clear", d[7], 1);
      while (!(((m_pre + 1) % 2) == 0 && m_cnt == 4'(CNT_MAX))) @(negedge clk);
      bus_write(1'b0, 8'h24);
      bus_read(1'b1, d);
      bus_read(1'b0, d); chk("R7 hardware set wins", d[7], 1);
      chk("R8 irq with flag set", ovf_irq, 1);
      bus_write(1'b0, 8'hE4);
      bus_read(1'b0, d); chk("R6 written one ignored", d[7], 1);
      bus_write(1'b0, 8'h24);
      bus_read(1'b0, d); chk("R6 armed zero clears", d[7], 0);
      bus_write(1'b0, 8'hE4);
      bus_read(1'b1, d);
      bus_read(1'b0, d); chk("R6 one cannot set flag", d[7], 0);
      while (!m_ctrl[7]) @(negedge clk);
      bus_write(1'b0, 8'h24);
      bus_read(1'b1, d);
      bus_read(1'b0, d); chk("R6 unarmed zero keeps flag", d[7], 1);

      // R9 and R10 pin edge timing, rising-edge clear and request
      cap_in = 1'b0;
      bus_write(1'b0, 8'h18);
      repeat (6) @(negedge clk);
      while (m_cnt < 4) @(negedge clk);
      cap_in = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R10 capture pulse after two edges", cap_irq, 1);
      @(posedge clk); @(negedge clk);
      chk("R10 capture pulse ends", cap_irq, 0);
      bus_read(1'b1, d); chk("R9 clear on third edge", d, 0);
      read_model(1'b0, "R9 clear is not an overflow");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule